// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two parallel buses, called A and B, and moves data between them in either direction. Each direction has its own storage register with its own capture clock. The A-to-B register samples the A bus, and the B-to-A register samples the B bus. The value put onto the opposite bus is either the live value of the source bus or the value held in that direction's register. A per-direction select makes the choice. The path can then be inverted bit by bit when the `INVERT` parameter is set. The registers always hold the true, uninverted value.

Each direction has its own drive enable. The B-side enable is active high and the A-side enable is active low. With both off, both buses are isolated, yet the registers still capture. With both on, the block can drive stored A data onto B and stored B data onto A at the same time. For synthesis, each bus is split into an input port, an output port and an output-enable port. The surrounding tri-state logic (or a bench model of it) resolves the wire.

Each register has a synchronous active-high reset, sampled on that register's own capture clock.

Top module: `dual_reg_xcvr`

## Requirements
- R1: On every rising edge of `clkAtoB`, the A-to-B register loads `aIn`, whatever the selects and drive enables are.
- R2: On every rising edge of `clkBtoA`, the B-to-A register loads `bIn`, whatever the selects and drive enables are.
- R3: `bOut` carries the live `aIn` when `selAtoB` is 0, and the A-to-B register when `selAtoB` is 1.
- R4: `aOut` carries the live `bIn` when `selBtoA` is 0, and the B-to-A register when `selBtoA` is 1.
- R5: `bOutEn` is 1 exactly when `driveBEn` is 1 (active high).
- R6: `aOutEn` is 1 exactly when `driveAEnN` is 0 (active low).
- R7: With `driveBEn`=0 and `driveAEnN`=1, neither output enable is set, and both registers still capture on their clocks.
- R8: With `driveBEn`=1 and `driveAEnN`=0, both enables are set together. Stored A data then appears on `bOut` while stored B data appears on `aOut`.
- R9: Suppose the B bus is driven from live A data (`selAtoB`=0, `driveBEn`=1) and both clocks pulse together. The B-to-A register then captures the driven value. With `INVERT`=0, both registers hold the A data.
- R10: With `INVERT`=1, every bit of `aOut` and `bOut` is inverted after the select; with `INVERT`=0 data passes unchanged. The registers keep the true value.
- R11: A capture edge with `rst`=1 clears that register to zero.
- R12: Take live mode on both sides with both enables on, and let each bus be resolved only from the block's own outputs. Each output then equals the value already on the bus it drives, so both buses keep their values across cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkAtoB | input | 1 | Capture clock of the A-to-B register |
| clkBtoA | input | 1 | Capture clock of the B-to-A register |
| rst | input | 1 | Synchronous active-high clear, sampled on each capture clock |
| selAtoB | input | 1 | 0: live A onto B, 1: stored A onto B |
| selBtoA | input | 1 | 0: live B onto A, 1: stored B onto A |
| driveBEn | input | 1 | Active-high enable for driving the B bus |
| driveAEnN | input | 1 | Active-low enable for driving the A bus |
| aIn | input | WIDTH | Value present on the A bus |
| bIn | input | WIDTH | Value present on the B bus |
| aOut | output | WIDTH | Data offered to the A bus |
| aOutEn | output | 1 | Drive enable for the A bus |
| bOut | output | WIDTH | Data offered to the B bus |
| bOutEn | output | 1 | Drive enable for the B bus |

## Verification
The stored paths are tested by capturing one value, then changing the bus and reading the output again. This separates a register that holds its value from a path that only follows the live bus. Live mode is tried with the bus changing between clocks, which exposes a wrong select polarity. Captures are made under isolation, single-side drive and dual drive, to show that enables and selects never gate a clock. The non-inverting and inverting variants run side by side on the same stimulus. Directed sequences cover reset clearing, loading both registers from a single bus, and the loop-back case where each bus is fed only by the other side's output. Seeded random mixes of selects, enables, data and clock pulses follow.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;

  // Strobes from the control decoder to the two datapath lanes.
  typedef struct packed {
    logic showStoredOnB;
    logic showStoredOnA;
    logic driveB;
    logic driveA;
  } xcvrCtrl_t;

endpackage

// File: rtl/xcvr_ctrl.sv
`timescale 1ns/1ps
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic      selAtoB,
  input  logic      selBtoA,
  input  logic      driveBEn,
  input  logic      driveAEnN,
  output xcvrCtrl_t strobes
);

  // The two drive enables have opposite polarity; normalise to active high.
  always_comb begin
    strobes.showStoredOnB = selAtoB;
    strobes.showStoredOnA = selBtoA;
    strobes.driveB        = driveBEn;
    strobes.driveA        = ~driveAEnN;
  end

endmodule

// File: rtl/xcvr_lane.sv
`timescale 1ns/1ps
module xcvr_lane #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] srcData,
  input  logic             useStored,
  input  logic             drive,
  output logic [WIDTH-1:0] dstData,
  output logic             dstEn
);

  logic [WIDTH-1:0] storedData;
  logic [WIDTH-1:0] pickedData;

  // Capture is never gated: select and enable only affect the output side.
  always_ff @(posedge clk) begin
    if (rst) storedData <= '0;
    else     storedData <= srcData;
  end

  assign pickedData = useStored ? storedData : srcData;

  generate
    if (INVERT) begin : g_invert
      assign dstData = ~pickedData;
    end else begin : g_pass
      assign dstData = pickedData;
    end
  endgenerate

  assign dstEn = drive;

endmodule

// File: rtl/dual_reg_xcvr.sv
`timescale 1ns/1ps
module dual_reg_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic             clkAtoB,
  input  logic             clkBtoA,
  input  logic             rst,
  input  logic             selAtoB,
  input  logic             selBtoA,
  input  logic             driveBEn,
  input  logic             driveAEnN,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOutEn,
  output logic [WIDTH-1:0] bOut,
  output logic             bOutEn
);

  xcvrCtrl_t strobes;

  xcvr_ctrl ctrl_i (
    .selAtoB   (selAtoB),
    .selBtoA   (selBtoA),
    .driveBEn  (driveBEn),
    .driveAEnN (driveAEnN),
    .strobes   (strobes)
  );

  // A side feeds the B bus.
  xcvr_lane #(.WIDTH(WIDTH), .INVERT(INVERT)) laneAtoB_i (
    .clk       (clkAtoB),
    .rst       (rst),
    .srcData   (aIn),
    .useStored (strobes.showStoredOnB),
    .drive     (strobes.driveB),
    .dstData   (bOut),
    .dstEn     (bOutEn)
  );

  // B side feeds the A bus.
  xcvr_lane #(.WIDTH(WIDTH), .INVERT(INVERT)) laneBtoA_i (
    .clk       (clkBtoA),
    .rst       (rst),
    .srcData   (bIn),
    .useStored (strobes.showStoredOnA),
    .drive     (strobes.driveA),
    .dstData   (aOut),
    .dstEn     (aOutEn)
  );

endmodule

// File: rtl/xcvr_checker.sv
`timescale 1ns/1ps
module xcvr_checker #(
  parameter int WIDTH  = 8,
  parameter bit INVERT = 1'b0
) (
  input logic             clkAtoB,
  input logic             clkBtoA,
  input logic             rst,
  input logic             selAtoB,
  input logic             selBtoA,
  input logic             driveBEn,
  input logic             driveAEnN,
  input logic [WIDTH-1:0] aIn,
  input logic [WIDTH-1:0] bIn,
  input logic [WIDTH-1:0] aOut,
  input logic             aOutEn,
  input logic [WIDTH-1:0] bOut,
  input logic             bOutEn
);

  localparam logic [WIDTH-1:0] MASK = INVERT ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  AST_STORE_A_SEEN_ON_B: assert property (@(posedge clkAtoB) disable iff (rst)
    (!$past(rst) && selAtoB) |-> (bOut == ($past(aIn) ^ MASK))); // R1

  AST_STORE_B_SEEN_ON_A: assert property (@(posedge clkBtoA) disable iff (rst)
    (!$past(rst) && selBtoA) |-> (aOut == ($past(bIn) ^ MASK))); // R2

  AST_LIVE_A_ON_B: assert property (@(posedge clkAtoB) disable iff (rst)
    !selAtoB |-> (bOut == (aIn ^ MASK))); // R3

  AST_LIVE_B_ON_A: assert property (@(posedge clkBtoA) disable iff (rst)
    !selBtoA |-> (aOut == (bIn ^ MASK))); // R4

  AST_ISOLATION: assert property (@(posedge clkAtoB) disable iff (rst)
    (!driveBEn && driveAEnN) |-> (!aOutEn && !bOutEn)); // R7

  AST_DUAL_DRIVE: assert property (@(posedge clkBtoA) disable iff (rst)
    (driveBEn && !driveAEnN) |-> (aOutEn && bOutEn)); // R8

  AST_RESET_CLEARS_AB: assert property (@(posedge clkAtoB) disable iff (rst)
    ($past(rst) && selAtoB) |-> (bOut == MASK)); // R11

endmodule

bind dual_reg_xcvr xcvr_checker #(.WIDTH(WIDTH), .INVERT(INVERT)) chk_i (
  .clkAtoB   (clkAtoB),
  .clkBtoA   (clkBtoA),
  .rst       (rst),
  .selAtoB   (selAtoB),
  .selBtoA   (selBtoA),
  .driveBEn  (driveBEn),
  .driveAEnN (driveAEnN),
  .aIn       (aIn),
  .bIn       (bIn),
  .aOut      (aOut),
  .aOutEn    (aOutEn),
  .bOut      (bOut),
  .bOutEn    (bOutEn)
);

// File: tb/dual_reg_xcvr_tb_top.sv
`timescale 1ns/1ps
module dual_reg_xcvr_tb_top;

  localparam int W          = 8;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic clkAtoB = 1'b0;
  logic clkBtoA = 1'b0;
  logic rst = 1'b1;
  logic selAtoB = 1'b0;
  logic selBtoA = 1'b0;
  logic driveBEn = 1'b0;
  logic driveAEnN = 1'b1;
  logic [W-1:0] aIn [2];
  logic [W-1:0] bIn [2];
  logic [W-1:0] aOut [2];
  logic [W-1:0] bOut [2];
  logic aOutEn [2];
  logic bOutEn [2];

  logic [W-1:0] expAB [2];
  logic [W-1:0] expBA [2];

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Instance 0 passes data unchanged, instance 1 inverts.
  dual_reg_xcvr #(.WIDTH(W), .INVERT(1'b0)) dut_i (
    .clkAtoB(clkAtoB), .clkBtoA(clkBtoA), .rst(rst),
    .selAtoB(selAtoB), .selBtoA(selBtoA),
    .driveBEn(driveBEn), .driveAEnN(driveAEnN),
    .aIn(aIn[0]), .bIn(bIn[0]),
    .aOut(aOut[0]), .aOutEn(aOutEn[0]), .bOut(bOut[0]), .bOutEn(bOutEn[0])
  );

  dual_reg_xcvr #(.WIDTH(W), .INVERT(1'b1)) dutInv_i (
    .clkAtoB(clkAtoB), .clkBtoA(clkBtoA), .rst(rst),
    .selAtoB(selAtoB), .selBtoA(selBtoA),
    .driveBEn(driveBEn), .driveAEnN(driveAEnN),
    .aIn(aIn[1]), .bIn(bIn[1]),
    .aOut(aOut[1]), .aOutEn(aOutEn[1]), .bOut(bOut[1]), .bOutEn(bOutEn[1])
  );

  function automatic logic [W-1:0] msk(input int v);
    return (v == 1) ? {W{1'b1}} : {W{1'b0}};
  endfunction

  function automatic logic [W-1:0] expBOut(input int v);
    return (selAtoB ? expAB[v] : aIn[v]) ^ msk(v);
  endfunction

  function automatic logic [W-1:0] expAOut(input int v);
    return (selBtoA ? expBA[v] : bIn[v]) ^ msk(v);
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    for (int v = 0; v < 2; v++) begin
      check({tag, " bOut"}, bOut[v], expBOut(v));
      check({tag, " aOut"}, aOut[v], expAOut(v));
      check({tag, " bOutEn R5"}, {{(W-1){1'b0}}, bOutEn[v]}, {{(W-1){1'b0}}, driveBEn});
      check({tag, " aOutEn R6"}, {{(W-1){1'b0}}, aOutEn[v]}, {{(W-1){1'b0}}, ~driveAEnN});
    end
  endtask

  // Pulse chosen capture clocks; model the capture at the rising edge.
  task automatic pulse(input bit doAB, input bit doBA);
    #2;
    for (int v = 0; v < 2; v++) begin
      if (doAB) expAB[v] = rst ? '0 : aIn[v];
      if (doBA) expBA[v] = rst ? '0 : bIn[v];
    end
    clkAtoB = doAB;
    clkBtoA = doBA;
    #3;
    clkAtoB = 1'b0;
    clkBtoA = 1'b0;
    #2;
  endtask

  task automatic setBoth(input logic [W-1:0] a, input logic [W-1:0] b);
    for (int v = 0; v < 2; v++) begin
      aIn[v] = a;
      bIn[v] = b;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    setBoth('0, '0);
    for (int v = 0; v < 2; v++) begin
      expAB[v] = '0;
      expBA[v] = '0;
    end
    void'($urandom(32'h00C0FFEE));

    // R11: synchronous clear on both capture clocks
    setBoth(8'h77, 8'h99);
    pulse(1, 1);
    pulse(1, 1);
    rst = 1'b0;
    selAtoB = 1'b1;
    selBtoA = 1'b1;
    #1;
    for (int v = 0; v < 2; v++) begin
      check("R11 cleared A-to-B", bOut[v], msk(v));
      check("R11 cleared B-to-A", aOut[v], msk(v));
    end
    checkAll("R5/R6 reset state");

    // R1/R3: stored versus live on B
    setBoth(8'hA5, 8'h00);
    pulse(1, 0);
    setBoth(8'h3C, 8'h00);
    #1;
    for (int v = 0; v < 2; v++) check("R1 stored held on B", bOut[v], 8'hA5 ^ msk(v));
    selAtoB = 1'b0;
    #1;
    for (int v = 0; v < 2; v++) check("R3 live A on B", bOut[v], 8'h3C ^ msk(v));

    // R2/R4: stored versus live on A
    setBoth(8'h00, 8'h5E);
    pulse(0, 1);
    setBoth(8'h00, 8'hE1);
    #1;
    for (int v = 0; v < 2; v++) check("R2 stored held on A", aOut[v], 8'h5E ^ msk(v));
    selBtoA = 1'b0;
    #1;
    for (int v = 0; v < 2; v++) check("R4 live B on A", aOut[v], 8'hE1 ^ msk(v));

    // R7: isolation still captures
    driveBEn = 1'b0;
    driveAEnN = 1'b1;
    setBoth(8'h12, 8'h34);
    pulse(1, 1);
    selAtoB = 1'b1;
    selBtoA = 1'b1;
    #1;
    for (int v = 0; v < 2; v++) begin
      check("R7 no A drive", {{(W-1){1'b0}}, aOutEn[v]}, '0);
      check("R7 no B drive", {{(W-1){1'b0}}, bOutEn[v]}, '0);
      check("R7 capture A-to-B", bOut[v], 8'h12 ^ msk(v));
      check("R7 capture B-to-A", aOut[v], 8'h34 ^ msk(v));
    end

    // R8: both buses driven with stored data
    driveBEn = 1'b1;
    driveAEnN = 1'b0;
    setBoth(8'hC3, 8'h69);
    pulse(1, 1);
    setBoth(8'h00, 8'hFF);
    #1;
    for (int v = 0; v < 2; v++) begin
      check("R8 A enable", {{(W-1){1'b0}}, aOutEn[v]}, 8'h01);
      check("R8 B enable", {{(W-1){1'b0}}, bOutEn[v]}, 8'h01);
      check("R8 stored A on B", bOut[v], 8'hC3 ^ msk(v));
      check("R8 stored B on A", aOut[v], 8'h69 ^ msk(v));
    end

    // R9: B bus driven from live A, both clocks together
    selAtoB = 1'b0;
    selBtoA = 1'b1;
    driveBEn = 1'b1;
    driveAEnN = 1'b1;
    for (int v = 0; v < 2; v++) aIn[v] = 8'h5A;
    #1;
    for (int v = 0; v < 2; v++) bIn[v] = bOut[v];
    pulse(1, 1);
    selAtoB = 1'b1;
    #1;
    for (int v = 0; v < 2; v++) begin
      check("R9 A-to-B holds A data", bOut[v], 8'h5A ^ msk(v));
      check("R9 B-to-A holds driven B", aOut[v], 8'h5A);
    end
    check("R9 both registers equal A", aOut[0], bOut[0]);

    // R10: inversion after the select, registers in true form
    selAtoB = 1'b0;
    setBoth(8'h0F, 8'h81);
    selBtoA = 1'b0;
    #1;
    check("R10 inverting live B", bOut[1], 8'hF0);
    check("R10 non-inverting live B", bOut[0], 8'h0F);
    check("R10 inverting live A", aOut[1], 8'h7E);
    pulse(1, 0);
    selAtoB = 1'b1;
    #1;
    check("R10 inverted stored copy", bOut[1], ~bOut[0]);

    // R12: loop-back, each bus fed only by the block's own output
    selAtoB = 1'b0;
    selBtoA = 1'b0;
    driveBEn = 1'b1;
    driveAEnN = 1'b0;
    for (int v = 0; v < 2; v++) begin
      aIn[v] = 8'h96;
      bIn[v] = 8'h96 ^ msk(v);
    end
    for (int c = 0; c < 4; c++) begin
      #1;
      for (int v = 0; v < 2; v++) begin
        check("R12 A bus kept", aOut[v], 8'h96);
        check("R12 B bus kept", bOut[v], 8'h96 ^ msk(v));
        aIn[v] = aOut[v];
        bIn[v] = bOut[v];
      end
      pulse(1, 1);
    end

    // Random mix, R1/R2 captures and R3/R4 output selection
    for (int i = 0; i < 300; i++) begin
      selAtoB   = 1'($urandom);
      selBtoA   = 1'($urandom);
      driveBEn  = 1'($urandom);
      driveAEnN = 1'($urandom);
      for (int v = 0; v < 2; v++) begin
        aIn[v] = W'($urandom);
        bIn[v] = W'($urandom);
      end
      #1;
      checkAll("R3/R4 random before edge");
      pulse(1'($urandom), 1'($urandom));
      checkAll("R1/R2 random after edge");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule